// File: doc/BRIEF.md
# Indirect PHY Register Access Master

This block is a hardware sequencer for 16-bit PHY registers that sit behind a control/status word pair rather than in the memory map. A caller issues one request carrying a direction, a 16-bit PHY register address and, for writes, 16 bits of data. The sequencer then walks through the handshake steps on its own. It drives a 20-bit control word and watches the acknowledge bit and the data field of a 17-bit status word. When the transfer ends it pulses `done`, together with `err_timeout` if it gave up.

Every strobe in the control word is a complete four-phase exchange. The sequencer raises the strobe, waits for the acknowledge to go high, drops the strobe and waits for the acknowledge to go low. Each wait samples the acknowledge a limited number of times (`MAX_POLLS`), spaced `CYC_PER_US` clock cycles apart. If the expected level is never seen, the sequencer abandons the transfer.

Control word layout (bit positions are behaviour, the PHY decodes them):
- bits 15:0 hold the address or data field;
- bit 16 captures the address;
- bit 17 captures the data;
- bit 18 is the write strobe;
- bit 19 is the read strobe.

Status word layout:
- bit 16 is the acknowledge;
- bits 15:0 hold the read data.

Top module: `phy_ia_master`

## Requirements
- R1: After reset `busy`, `done` and `err_timeout` are 0, `ctl_word` is 0 and `rd_data` is 0.
- R2: A request (`req_valid` high) is taken only while `busy` is 0; a request presented while busy is dropped and never reaches the PHY.
- R3: Every transfer starts with an address phase. First the address appears in bits 15:0 with no strobe. Then bit 16 is added, with the address in bits 15:0. After the acknowledge goes high the address is driven alone, and the sequencer waits for the acknowledge to go low.
- R4: A write goes through these steps, then `ctl_word` returns to 0:
  - the data is driven alone for one cycle;
  - the data is driven with bit 17, with a wait for acknowledge high, then the data alone with a wait for acknowledge low;
  - bit 18 is driven alone (field 0), with a wait for acknowledge high;
  - the data is driven alone, with a wait for acknowledge low.
- R5: A read drives bit 19 alone (field 0) and waits for acknowledge high. It takes status bits 15:0 at that sample, then drives 0 and waits for acknowledge low. On success `rd_data` shows the value taken.
- R6: At most one of control bits 16..19 is high in any cycle.
- R7: The first sample of a wait is taken one cycle after the step's control value appears. Later samples follow every `CYC_PER_US` cycles, up to `MAX_POLLS` samples. If the acknowledge never reaches the expected level during the first wait, `done` rises `2 + (MAX_POLLS-1)*CYC_PER_US` clock edges after the accepting edge.
- R8: On a timeout `done` and `err_timeout` pulse together for one cycle, `ctl_word` goes to 0, the block is idle again and `rd_data` keeps its previous value.
- R9: `busy` is high from the cycle after acceptance until `done` rises, and falls in the cycle `done` rises. `done` lasts one cycle.
- R10: An acknowledge that first becomes visible at the last permitted sample still completes the step without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_timeout | output | 1 | Pulses with `done` when a wait ran out of samples |
| rd_data | output | 16 | Result of the last successful read |
| ctl_word | output | 20 | Control word to the PHY |
| stat_word | input | 17 | Status word from the PHY |

## Verification
A sequencer stuck on the wrong step, or one that skips a step, shows up at once on `ctl_word`. The PHY model then latches the wrong address or data, and the very next read of that register returns a wrong value. A miscounted prescaler or retry counter moves the edge at which `done` rises on a timed-out transfer. It also breaks the exact boundary between the last acknowledge that still succeeds and the first one that times out. Either error is visible within one transfer. Loose result handling would show as `rd_data` moving after a failed read.

// File: rtl/phy_ia_pkg.sv
package phy_ia_pkg;
  localparam int PHY_DW  = 16;
  localparam int STRB_N  = 4;
  localparam int CTL_W   = PHY_DW + STRB_N;
  localparam int STAT_W  = PHY_DW + 1;
  localparam int ACK_POS = PHY_DW;
  localparam int STEP_W  = 4;

  // strobe nibble order is {read, write, capture-data, capture-address}
  localparam logic [STRB_N-1:0] S_NONE = 4'b0000;
  localparam logic [STRB_N-1:0] S_CAPA = 4'b0001;
  localparam logic [STRB_N-1:0] S_CAPD = 4'b0010;
  localparam logic [STRB_N-1:0] S_WR   = 4'b0100;
  localparam logic [STRB_N-1:0] S_RD   = 4'b1000;

  typedef enum logic [1:0] {WT_NONE = 2'd0, WT_HIGH = 2'd1, WT_LOW = 2'd2} wait_e;

  typedef struct packed {
    logic [CTL_W-1:0] ctl;
    wait_e            wt;
    logic             grab;
    logic             last;
  } step_t;

  function automatic logic [CTL_W-1:0] ctl_pack(input logic [STRB_N-1:0] s,
                                                input logic [PHY_DW-1:0] f);
    return {s, f};
  endfunction

  function automatic step_t mk_step(input logic [STRB_N-1:0] s, input logic [PHY_DW-1:0] f,
                                    input wait_e w, input logic g, input logic l);
    step_t r;
    r.ctl  = ctl_pack(s, f);
    r.wt   = w;
    r.grab = g;
    r.last = l;
    return r;
  endfunction

  // Step table: address phase 0..2, then write 3..8 or read 3..4.
  function automatic step_t step_info(input logic [STEP_W-1:0] s, input logic wr,
                                      input logic [PHY_DW-1:0] a, input logic [PHY_DW-1:0] d);
    step_t r;
    r = mk_step(S_NONE, '0, WT_NONE, 1'b0, 1'b1);
    case (s)
      4'd0: r = mk_step(S_NONE, a, WT_NONE, 1'b0, 1'b0);
      4'd1: r = mk_step(S_CAPA, a, WT_HIGH, 1'b0, 1'b0);
      4'd2: r = mk_step(S_NONE, a, WT_LOW,  1'b0, 1'b0);
      4'd3: r = wr ? mk_step(S_NONE, d,  WT_NONE, 1'b0, 1'b0)
                   : mk_step(S_RD,   '0, WT_HIGH, 1'b1, 1'b0);
      4'd4: r = wr ? mk_step(S_CAPD, d,  WT_HIGH, 1'b0, 1'b0)
                   : mk_step(S_NONE, '0, WT_LOW,  1'b0, 1'b1);
      4'd5: if (wr) r = mk_step(S_NONE, d,  WT_LOW,  1'b0, 1'b0);
      4'd6: if (wr) r = mk_step(S_WR,   '0, WT_HIGH, 1'b0, 1'b0);
      4'd7: if (wr) r = mk_step(S_NONE, d,  WT_LOW,  1'b0, 1'b0);
      default: r = mk_step(S_NONE, '0, WT_NONE, 1'b0, 1'b1);
    endcase
    return r;
  endfunction

  function automatic logic ack_matches(input wait_e w, input logic ack);
    return (w == WT_HIGH) ? ack : !ack;
  endfunction
endpackage

// File: rtl/phy_ia_steps.sv
module phy_ia_steps
  import phy_ia_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic              wr,
  input  logic [PHY_DW-1:0] addr,
  input  logic [PHY_DW-1:0] wdata,
  output step_t             cur,
  output step_t             nxt
);
  step_t look [2];

  for (genvar k = 0; k < 2; k++) begin : g_look
    assign look[k] = step_info(step + STEP_W'(k), wr, addr, wdata);
  end

  assign cur = look[0];
  assign nxt = look[1];
endmodule

// File: rtl/phy_ia_pacer.sv
module phy_ia_pacer #(
  parameter int CYC_PER_US = 125,
  parameter int MAX_POLLS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  input  logic miss,
  output logic poll,
  output logic final_try
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int TW = (MAX_POLLS  > 1) ? $clog2(MAX_POLLS)  : 1;
  localparam logic [PW-1:0] RELOAD   = PW'(CYC_PER_US - 1);
  localparam logic [TW-1:0] LAST_TRY = TW'(MAX_POLLS - 1);

  logic [PW-1:0] presc_q;
  logic [TW-1:0] tries_q;

  assign poll      = active && (presc_q == '0);
  assign final_try = (tries_q == LAST_TRY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
      tries_q <= '0;
    end else if (arm) begin
      presc_q <= '0;
      tries_q <= '0;
    end else if (active) begin
      if (presc_q == '0) begin
        if (miss) begin
          presc_q <= RELOAD;
          tries_q <= tries_q + 1'b1;
        end
      end else begin
        presc_q <= presc_q - 1'b1;
      end
    end
  end

  // R7
  first_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!active || poll));

  if (CYC_PER_US > 1) begin : g_gap
    // R7
    poll_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll && miss && !final_try) |=> !poll);
  end
endmodule

// File: rtl/phy_ia_master.sv
module phy_ia_master
  import phy_ia_pkg::*;
#(
  parameter int CYC_PER_US = 125,
  parameter int MAX_POLLS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PHY_DW-1:0] req_addr,
  input  logic [PHY_DW-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err_timeout,
  output logic [PHY_DW-1:0] rd_data,
  output logic [CTL_W-1:0]  ctl_word,
  input  logic [STAT_W-1:0] stat_word
);
  logic              run_q, op_wr_q, done_q, err_q;
  logic [PHY_DW-1:0] addr_q, wdata_q, grab_q, rd_q;
  logic [STEP_W-1:0] step_q;
  logic [CTL_W-1:0]  ctl_q;

  step_t cur, nxt, first;
  logic  accept, in_wait, ack_hit, poll, final_try;
  logic  step_adv, step_miss, give_up;

  assign first = step_info('0, req_write, req_addr, req_wdata);

  phy_ia_steps u_steps (
    .step  (step_q),
    .wr    (op_wr_q),
    .addr  (addr_q),
    .wdata (wdata_q),
    .cur   (cur),
    .nxt   (nxt)
  );

  assign accept    = !run_q && req_valid;
  assign in_wait   = run_q && (cur.wt != WT_NONE);
  assign ack_hit   = ack_matches(cur.wt, stat_word[ACK_POS]);
  assign step_adv  = run_q && ((cur.wt == WT_NONE) || (poll && ack_hit));
  assign step_miss = in_wait && poll && !ack_hit;
  assign give_up   = step_miss && final_try;

  phy_ia_pacer #(.CYC_PER_US(CYC_PER_US), .MAX_POLLS(MAX_POLLS)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (accept || (step_adv && !cur.last)),
    .active    (in_wait),
    .miss      (step_miss),
    .poll      (poll),
    .final_try (final_try)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      op_wr_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      step_q  <= '0;
      ctl_q   <= '0;
      grab_q  <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        run_q   <= 1'b1;
        op_wr_q <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        step_q  <= '0;
        ctl_q   <= first.ctl;
      end else if (give_up) begin
        run_q  <= 1'b0;
        ctl_q  <= '0;
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end else if (step_adv) begin
        if (cur.grab) grab_q <= stat_word[PHY_DW-1:0];
        if (cur.last) begin
          run_q  <= 1'b0;
          ctl_q  <= '0;
          done_q <= 1'b1;
          if (!op_wr_q) rd_q <= cur.grab ? stat_word[PHY_DW-1:0] : grab_q;
        end else begin
          step_q <= step_q + 1'b1;
          ctl_q  <= nxt.ctl;
        end
      end
    end
  end

  assign busy        = run_q;
  assign done        = done_q;
  assign err_timeout = err_q;
  assign rd_data     = rd_q;
  assign ctl_word    = ctl_q;

  // R1
  idle_ctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ctl_word == '0));
  // R2
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctl_word[CTL_W-1:PHY_DW]) <= 1);
  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> done);
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> (done && !err_timeout));
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/phy_ia_master_tb.sv
module phy_ia_master_tb;
  localparam int C = 4;
  localparam int M = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        busy, done, err_timeout;
  logic [15:0] rd_data;
  logic [19:0] ctl_word;
  logic [16:0] stat_word;

  int errors = 0, checks = 0, mon_err = 0, mon_chk = 0;

  always #4 clk = ~clk;

  phy_ia_master #(.CYC_PER_US(C), .MAX_POLLS(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err_timeout(err_timeout), .rd_data(rd_data), .ctl_word(ctl_word),
    .stat_word(stat_word));

  function automatic int tmo_latency(int c, int m);
    return 2 + (m - 1) * c;
  endfunction
  function automatic bit ack_in_time(int d, int c, int m);
    return d <= (m - 1) * c - 1;
  endfunction
  function automatic logic [15:0] seed_val(int i);
    return 16'(i * 257) ^ 16'h3C5A;
  endfunction

  // ---------------- PHY model ----------------
  int          ack_delay = 1;
  bit          stick_rd = 0;
  logic [15:0] cur_addr = '0, cur_wdata = '0;
  logic        ack_m, rd_hi;
  int          hold;
  logic [15:0] cap_addr, cap_data, rdata_m;
  logic [15:0] phy_mem [64];
  logic        tgt;

  assign tgt = |ctl_word[19:16];
  assign stat_word = {ack_m, (ack_m && rd_hi) ? rdata_m : 16'hA5C3};

  always @(posedge clk) begin
    if (!rst_n) begin
      ack_m <= 1'b0; rd_hi <= 1'b0; hold <= 0;
      cap_addr <= '0; cap_data <= '0; rdata_m <= '0;
      for (int i = 0; i < 64; i++) phy_mem[i] <= seed_val(i);
    end else if (ack_m != tgt) begin
      if (!tgt && stick_rd && rd_hi) begin
        hold <= 0;
      end else if (hold >= ack_delay) begin
        ack_m <= tgt;
        hold  <= 0;
        if (tgt) begin
          rd_hi <= ctl_word[19];
          mon_chk++;
          if (ctl_word[16] && ctl_word[15:0] !== cur_addr) begin
            mon_err++; $display("FAIL R3: captured address %h expected %h", ctl_word[15:0], cur_addr);
          end
          if (ctl_word[17] && ctl_word[15:0] !== cur_wdata) begin
            mon_err++; $display("FAIL R4: captured data %h expected %h", ctl_word[15:0], cur_wdata);
          end
          if ((ctl_word[18] || ctl_word[19]) && ctl_word[15:0] !== 16'h0) begin
            mon_err++; $display("FAIL R4: strobe field %h expected 0000", ctl_word[15:0]);
          end
          if (ctl_word[16]) cap_addr <= ctl_word[15:0];
          if (ctl_word[17]) cap_data <= ctl_word[15:0];
          if (ctl_word[18]) phy_mem[cap_addr[5:0]] <= cap_data;
          if (ctl_word[19]) rdata_m <= phy_mem[cap_addr[5:0]];
        end
      end else begin
        hold <= hold + 1;
      end
    end else begin
      hold <= 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [15:0] a, input logic [15:0] d,
                      input int dly, output int lat, output bit e);
    bit busy_ok;
    cur_addr = a; cur_wdata = d; ack_delay = dly;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
    chk(ctl_word === {4'b0, a}, "R3 first control value", 32'(ctl_word), 32'({4'b0, a}));
    lat = 0; busy_ok = 1;
    while (done !== 1'b1 && lat < 4000) begin
      @(posedge clk); #1;
      lat++;
      if (done !== 1'b1 && busy !== 1'b1) busy_ok = 0;
    end
    e = err_timeout;
    chk(busy_ok && busy === 1'b0, "R9 busy span", 32'(busy), 32'd0);
    chk(ctl_word === '0, e ? "R8 control zero after timeout" : "R4 control zero at end",
        32'(ctl_word), 32'd0);
    @(posedge clk); #1;
    chk(done === 1'b0 && err_timeout === 1'b0, "R9 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic settle();
    ack_delay = 1;
    repeat (120) @(posedge clk);
  endtask

  // ---------------- stimulus ----------------
  logic [15:0] shadow [64];
  int          lat;
  bit          e;

  initial begin
    logic [15:0] prev;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) shadow[i] = seed_val(i);
    repeat (3) @(posedge clk);
    #1;
    chk(busy === 0 && done === 0 && err_timeout === 0, "R1 flags after reset", 32'({busy, done, err_timeout}), 32'd0);
    chk(ctl_word === '0 && rd_data === '0, "R1 words after reset", 32'(ctl_word), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // directed write then read
    xfer(1'b1, 16'h1234, 16'hBEEF, 2, lat, e);
    shadow[6'h34] = 16'hBEEF;
    chk(!e, "R4 directed write", 32'(e), 32'd0);
    xfer(1'b0, 16'h1234, 16'h0000, 2, lat, e);
    chk(!e && rd_data === 16'hBEEF, "R5 directed read", 32'(rd_data), 32'hBEEF);

    // random mix
    for (int n = 0; n < 40; n++) begin
      bit          wr;
      logic [15:0] a, d;
      int          dly;
      wr = 1'($urandom % 2); a = 16'($urandom); d = 16'($urandom); dly = int'($urandom % 7);
      xfer(wr, a, d, dly, lat, e);
      if (wr) begin
        shadow[a[5:0]] = d;
        chk(!e, "R4 random write", 32'(e), 32'd0);
      end else begin
        chk(!e && rd_data === shadow[a[5:0]], "R5 random read", 32'(rd_data), 32'(shadow[a[5:0]]));
      end
    end

    // last-sample boundary succeeds
    xfer(1'b1, 16'h0207, 16'h7E57, (M - 1) * C - 1, lat, e);
    shadow[6'h07] = 16'h7E57;
    chk(e == !ack_in_time((M - 1) * C - 1, C, M), "R10 late ack write", 32'(e), 32'd0);
    xfer(1'b0, 16'h0207, 16'h0000, (M - 1) * C - 1, lat, e);
    chk(!e && rd_data === 16'h7E57, "R10 late ack read", 32'(rd_data), 32'h7E57);
    settle();

    // one cycle too late: timeout on first wait
    prev = rd_data;
    xfer(1'b1, 16'h0009, 16'hDEAD, (M - 1) * C, lat, e);
    chk(e == 1'b1, "R8 timeout flagged", 32'(e), 32'd1);
    chk(lat == tmo_latency(C, M), "R7 timeout latency", 32'(lat), 32'(tmo_latency(C, M)));
    chk(rd_data === prev, "R8 rd_data kept on write timeout", 32'(rd_data), 32'(prev));
    settle();
    xfer(1'b0, 16'h0009, 16'h0000, 1, lat, e);
    chk(!e && rd_data === shadow[6'h09], "R8 aborted write left register", 32'(rd_data), 32'(shadow[6'h09]));

    // read timing out on its final ack-low wait
    prev = rd_data;
    stick_rd = 1;
    xfer(1'b0, 16'h0011, 16'h0000, 1, lat, e);
    chk(e == 1'b1, "R8 read timeout flagged", 32'(e), 32'd1);
    chk(rd_data === prev, "R8 rd_data kept on read timeout", 32'(rd_data), 32'(prev));
    stick_rd = 0;
    settle();

    // request while busy is dropped
    cur_addr = 16'h0003; cur_wdata = 16'h4444; ack_delay = 3;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0003; req_wdata = 16'h4444;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0005; req_wdata = 16'h9999;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int guard = 0;
      while (done !== 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
    end
    shadow[6'h03] = 16'h4444;
    begin
      bit again = 0;
      for (int k = 0; k < 30; k++) begin @(negedge clk); if (busy) again = 1; end
      chk(!again, "R2 no second transfer", 32'(again), 32'd0);
    end
    xfer(1'b0, 16'h0005, 16'h0000, 1, lat, e);
    chk(!e && rd_data === shadow[6'h05], "R2 busy request dropped", 32'(rd_data), 32'(shadow[6'h05]));
    xfer(1'b0, 16'h0003, 16'h0000, 1, lat, e);
    chk(!e && rd_data === 16'h4444, "R4 write under dropped request", 32'(rd_data), 32'h4444);

    chk(mon_chk > 0, "R6 strobe monitor active", 32'(mon_chk), 32'd1);
    errors += mon_err;
    checks += mon_chk;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors + mon_err + 1, checks + mon_chk + 1);
    $finish;
  end
endmodule